// File: doc/BRIEF.md
# Timer Configuration Register Bank

This block is the configuration front end of a timer/counter. Software reaches it through a plain 32-bit register bus with word-aligned byte addresses. A write strobe selects one register by address, and the read data is a combinational function of the address. The block holds one control word and six further words:

- two fault setup words
- a waveform extension word
- an output drive word
- an event routing word
- a debug word

It drives the decoded fields of these words straight to the counter core.

The control word carries three bits that may be written at any moment: run enable, a run-in-standby flag and a self-clearing soft reset. Every other configuration field is frozen while the timer runs, so a setup cannot change under a live counter. A write that turns the timer on also loads the frozen control fields in the same access. A write that turns it off loads only the enable bit.

A soft reset takes one cycle to arm and clears the bank on the next edge. The debug word survives it. A prescaler field is also decoded into a one-hot divide ratio for the core.

Top module: `tmr_cfg_bank`

## Requirements
- R1: After `rst_n` is released, every register reads 0, `tmr_en` is 0 and `presc_ratio` is 1.
- R2: While `tmr_en` is 1, writes to the fault words (0x04, 0x08), waveform extension (0x0C), drive (0x10) and event (0x14) registers leave them unchanged, raise no error, and reads return the stored value.
- R3: While `tmr_en` is 0, writes to those registers store the write data masked to their implemented bits: 0x04, 0x08 and 0x14 keep bits [15:0], 0x0C keeps bits [23:0], 0x10 keeps all 32 bits. Unimplemented bits read 0.
- R4: Control word (0x00) layout: bit 1 run enable, bit 2 run-in-standby, bits [6:4] prescaler select, bits [9:8] prescaler sync mode, bits [16+CH-1:16] capture enables. Bits 1 and 2 take every control write. The other fields load only when `tmr_en` was 0 before the write. So a write that sets enable loads them too, and a write that clears enable leaves them unchanged.
- R5: A control write with bit 0 set raises `srst_busy`, and control bit 0 reads 1 for that one cycle. All other fields of that write are ignored.
- R6: On the edge after `srst_busy` is raised, all registers except the debug word return to their reset values, and `tmr_en` and `srst_busy` become 0.
- R7: The debug word (0x18, bit 0 only) can be written whether the timer is enabled or not. It keeps its value through a soft reset.
- R8: Every write issued while `srst_busy` is 1 is dropped, including writes to the debug word.
- R9: `presc_ratio` decodes the prescaler select 0..7 to the divide ratios 1, 2, 4, 8, 16, 64, 256 and 1024.
- R10: Writes to an address that is not one of the seven word addresses 0x00..0x18 change nothing, and reads of such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| tmr_en | output | 1 | Timer run enable |
| tmr_stby_run | output | 1 | Keep running in standby |
| srst_busy | output | 1 | Soft reset armed, clears bank next edge |
| presc_sel | output | 3 | Prescaler select field |
| presc_sync | output | 2 | Prescaler sync mode field |
| presc_ratio | output | 11 | One-hot divide ratio |
| cap_en | output | CH | Per-channel capture enables |
| flt_a_cfg | output | 32 | Fault setup word A |
| flt_b_cfg | output | 32 | Fault setup word B |
| wext_cfg | output | 32 | Waveform extension word |
| drv_cfg | output | 32 | Output drive word |
| evt_cfg | output | 32 | Event routing word |
| dbg_cfg | output | 1 | Debug bit, survives soft reset |

## Verification
The hardest situation to reach is a write that lands inside the single cycle in which a soft reset is armed but has not yet cleared the bank. The bench reaches it with an unbroken two-cycle strobe. The first beat arms the reset while the timer runs with a set debug bit. The second beat, on the very next edge, tries to clear the debug word. The bench then checks that the bank cleared, the debug bit survived and the dropped write left no trace. The enable-edge rules are reached in the same directed way: one access sets enable and changes the frozen control fields, and a later access clears enable and tries to change them again.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;

  localparam int NREG = 7;

  typedef logic [31:0] word_t;

  // register index = byte address / 4
  localparam int RG_CTRL = 0;
  localparam int RG_FLTA = 1;
  localparam int RG_FLTB = 2;
  localparam int RG_WEXT = 3;
  localparam int RG_DRV  = 4;
  localparam int RG_EVT  = 5;
  localparam int RG_DBG  = 6;

  // control word bit positions
  localparam int CB_SRST     = 0;
  localparam int CB_EN       = 1;
  localparam int CB_STBY     = 2;
  localparam int CB_DIV_LSB  = 4;
  localparam int DIV_W       = 3;
  localparam int CB_SYNC_LSB = 8;
  localparam int SYNC_W      = 2;
  localparam int CB_CAP_LSB  = 16;

  function automatic word_t reg_mask(input int idx);
    case (idx)
      RG_FLTA, RG_FLTB, RG_EVT: return 32'h0000_FFFF;
      RG_WEXT:                  return 32'h00FF_FFFF;
      RG_DRV:                   return 32'hFFFF_FFFF;
      RG_DBG:                   return 32'h0000_0001;
      default:                  return 32'h0000_0000;
    endcase
  endfunction

  // fields of the control word that are frozen while running
  function automatic word_t ctrl_prot_mask(input int ch);
    word_t m;
    m = (word_t'((1 << DIV_W) - 1) << CB_DIV_LSB)
      | (word_t'((1 << SYNC_W) - 1) << CB_SYNC_LSB)
      | (word_t'((64'd1 << ch) - 64'd1) << CB_CAP_LSB);
    return m;
  endfunction

  // select 0..4 -> shift by select, 5..7 -> shift by 2*select-4
  function automatic logic [10:0] presc_ratio_of(input logic [2:0] sel);
    int sh;
    sh = (sel <= 3'd4) ? int'(sel) : (2 * int'(sel) - 4);
    return 11'(1) << sh;
  endfunction

endpackage

// File: rtl/tmr_cfg_decode.sv
module tmr_cfg_decode
  import tmr_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel
);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i * 4));
  end

endmodule

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_cfg_pkg::*;
#(
  parameter word_t MASK      = 32'hFFFF_FFFF,
  parameter bit    PROTECT   = 1'b1,
  parameter bit    KEEP_SRST = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  word_t wdata,
  input  logic  prot_open,
  input  logic  srst_fire,
  output word_t q
);

  logic wr_take;
  assign wr_take = wr_hit && (prot_open || !PROTECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       q <= '0;
    else if (srst_fire && !KEEP_SRST) q <= '0;
    else if (wr_take)                 q <= wdata & MASK;
  end

endmodule

// File: rtl/tmr_cfg_ctrl.sv
module tmr_cfg_ctrl
  import tmr_cfg_pkg::*;
#(
  parameter int CH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  word_t wdata,
  output word_t q,
  output logic  en,
  output logic  stby,
  output logic  pend,
  output logic  srst_fire
);

  localparam word_t PMASK = ctrl_prot_mask(CH);

  word_t prot_q;
  logic  srst_req;

  assign srst_req  = wr_hit && wdata[CB_SRST];
  assign srst_fire = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      en     <= 1'b0;
      stby   <= 1'b0;
      prot_q <= '0;
    end else if (srst_fire) begin
      pend   <= 1'b0;
      en     <= 1'b0;
      stby   <= 1'b0;
      prot_q <= '0;
    end else if (srst_req) begin
      pend <= 1'b1;
    end else if (wr_hit) begin
      en   <= wdata[CB_EN];
      stby <= wdata[CB_STBY];
      // frozen fields follow the enable state before this write
      if (!en) prot_q <= wdata & PMASK;
    end
  end

  always_comb begin
    q           = prot_q;
    q[CB_SRST]  = pend;
    q[CB_EN]    = en;
    q[CB_STBY]  = stby;
  end

endmodule

// File: rtl/tmr_cfg_rdmux.sv
module tmr_cfg_rdmux
  import tmr_cfg_pkg::*;
(
  input  logic [NREG-1:0]        sel,
  input  logic [NREG-1:0][31:0]  regs,
  output word_t                  rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) rdata = rdata | regs[i];
    end
  end

endmodule

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank
  import tmr_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              tmr_en,
  output logic              tmr_stby_run,
  output logic              srst_busy,
  output logic [2:0]        presc_sel,
  output logic [1:0]        presc_sync,
  output logic [10:0]       presc_ratio,
  output logic [CH-1:0]     cap_en,
  output logic [31:0]       flt_a_cfg,
  output logic [31:0]       flt_b_cfg,
  output logic [31:0]       wext_cfg,
  output logic [31:0]       drv_cfg,
  output logic [31:0]       evt_cfg,
  output logic              dbg_cfg
);

  // named internal events
  logic [NREG-1:0]       sel;
  logic [NREG-1:0]       wr_hit;
  logic                  wr_go;
  logic                  prot_open;
  logic                  srst_fire;
  logic [NREG-1:0][31:0] regs;

  tmr_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  assign wr_go     = wr_en && !srst_busy;
  assign wr_hit    = sel & {NREG{wr_go}};
  assign prot_open = !tmr_en;

  tmr_cfg_ctrl #(.CH(CH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit[RG_CTRL]),
    .wdata     (wdata),
    .q         (regs[RG_CTRL]),
    .en        (tmr_en),
    .stby      (tmr_stby_run),
    .pend      (srst_busy),
    .srst_fire (srst_fire)
  );

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    tmr_cfg_reg #(
      .MASK      (reg_mask(i)),
      .PROTECT   (i != RG_DBG),
      .KEEP_SRST (i == RG_DBG)
    ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit[i]),
      .wdata     (wdata),
      .prot_open (prot_open),
      .srst_fire (srst_fire),
      .q         (regs[i])
    );
  end

  tmr_cfg_rdmux u_rd (
    .sel   (sel),
    .regs  (regs),
    .rdata (rdata)
  );

  assign presc_sel   = regs[RG_CTRL][CB_DIV_LSB +: DIV_W];
  assign presc_sync  = regs[RG_CTRL][CB_SYNC_LSB +: SYNC_W];
  assign cap_en      = regs[RG_CTRL][CB_CAP_LSB +: CH];
  assign presc_ratio = presc_ratio_of(presc_sel);
  assign flt_a_cfg   = regs[RG_FLTA];
  assign flt_b_cfg   = regs[RG_FLTB];
  assign wext_cfg    = regs[RG_WEXT];
  assign drv_cfg     = regs[RG_DRV];
  assign evt_cfg     = regs[RG_EVT];
  assign dbg_cfg     = regs[RG_DBG][0];

endmodule

// File: rtl/tmr_cfg_bank_chk.sv
module tmr_cfg_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int CH     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_srst,
  input logic              tmr_en,
  input logic              srst_busy,
  input logic              srst_fire,
  input logic [2:0]        presc_sel,
  input logic [1:0]        presc_sync,
  input logic [10:0]       presc_ratio,
  input logic [CH-1:0]     cap_en,
  input logic [31:0]       flt_a_cfg,
  input logic [31:0]       flt_b_cfg,
  input logic [31:0]       wext_cfg,
  input logic [31:0]       drv_cfg,
  input logic [31:0]       evt_cfg,
  input logic              dbg_cfg
);

  p_prot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !srst_busy) |=> $stable({flt_a_cfg, flt_b_cfg, wext_cfg, drv_cfg, evt_cfg}));

  p_ctrl_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !srst_busy) |=> $stable({presc_sel, presc_sync, cap_en}));

  p_srst_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wr_srst && !srst_busy) |=> srst_busy);

  p_srst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> (!tmr_en && !srst_busy && presc_sel == 3'd0 &&
                   (flt_a_cfg | flt_b_cfg | wext_cfg | drv_cfg | evt_cfg) == 32'd0));

  p_dbg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> $stable(dbg_cfg));

  p_ratio_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(presc_ratio) == 1);

endmodule

bind tmr_cfg_bank tmr_cfg_bank_chk #(.ADDR_W(ADDR_W), .CH(CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wr_srst     (wdata[0]),
  .tmr_en      (tmr_en),
  .srst_busy   (srst_busy),
  .srst_fire   (srst_fire),
  .presc_sel   (presc_sel),
  .presc_sync  (presc_sync),
  .presc_ratio (presc_ratio),
  .cap_en      (cap_en),
  .flt_a_cfg   (flt_a_cfg),
  .flt_b_cfg   (flt_b_cfg),
  .wext_cfg    (wext_cfg),
  .drv_cfg     (drv_cfg),
  .evt_cfg     (evt_cfg),
  .dbg_cfg     (dbg_cfg)
);

// File: tb/sim_tmr_cfg_bank.sv
`timescale 1ns/1ps
module sim_tmr_cfg_bank;

  localparam int ADDR_W = 8;
  localparam int CH     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              tmr_en, tmr_stby_run, srst_busy;
  logic [2:0]        presc_sel;
  logic [1:0]        presc_sync;
  logic [10:0]       presc_ratio;
  logic [CH-1:0]     cap_en;
  logic [31:0]       flt_a_cfg, flt_b_cfg, wext_cfg, drv_cfg, evt_cfg;
  logic              dbg_cfg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tmr_cfg_bank #(.ADDR_W(ADDR_W), .CH(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tmr_en(tmr_en), .tmr_stby_run(tmr_stby_run),
    .srst_busy(srst_busy), .presc_sel(presc_sel), .presc_sync(presc_sync),
    .presc_ratio(presc_ratio), .cap_en(cap_en), .flt_a_cfg(flt_a_cfg),
    .flt_b_cfg(flt_b_cfg), .wext_cfg(wext_cfg), .drv_cfg(drv_cfg),
    .evt_cfg(evt_cfg), .dbg_cfg(dbg_cfg)
  );

  function automatic logic [31:0] ctl(input bit en, input bit stby,
                                      input int dv, input int sy, input int cp);
    return (32'(en) << 1) | (32'(stby) << 2) | (32'(dv) << 4)
         | (32'(sy) << 8) | (32'(cp) << 16);
  endfunction

  function automatic logic [10:0] want_ratio(input int s);
    case (s)
      0: return 11'd1;    1: return 11'd2;    2: return 11'd4;
      3: return 11'd8;    4: return 11'd16;   5: return 11'd64;
      6: return 11'd256;  default: return 11'd1024;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(8'(i * 4), d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 tmr_en", 32'(tmr_en), 32'h0);
    chk("R1 presc_ratio", 32'(presc_ratio), 32'h1);
  endtask

  task automatic t_cfg_disabled();
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R3 fault A mask", d, 32'h0000_FFFF);
    wr(8'h08, 32'h1234_BEEF); chk("R3 fault B port", flt_b_cfg, 32'h0000_BEEF);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R3 wext mask", d, 32'h00FF_FFFF);
    wr(8'h10, 32'hA5A5_5A5A); rd(8'h10, d); chk("R3 drive", d, 32'hA5A5_5A5A);
    wr(8'h14, 32'h1234_5678); chk("R3 event port", evt_cfg, 32'h0000_5678);
  endtask

  task automatic t_enable_same_access();
    logic [31:0] d;
    wr(8'h00, ctl(1, 1, 5, 2, 4'hA));
    chk("R4 enable set", 32'(tmr_en), 32'h1);
    chk("R4 sel loaded with enable", 32'(presc_sel), 32'h5);
    chk("R4 cap loaded with enable", 32'(cap_en), 32'hA);
    chk("R9 ratio sel5", 32'(presc_ratio), 32'd64);
    rd(8'h00, d); chk("R4 ctrl readback", d, ctl(1, 1, 5, 2, 4'hA));
  endtask

  task automatic t_protect_running();
    logic [31:0] d;
    wr(8'h04, 32'h0000_1111); rd(8'h04, d); chk("R2 fault A held", d, 32'h0000_FFFF);
    wr(8'h10, 32'h0); rd(8'h10, d); chk("R2 drive held", d, 32'hA5A5_5A5A);
    wr(8'h0C, 32'h0); chk("R2 wext held", wext_cfg, 32'h00FF_FFFF);
    wr(8'h00, ctl(1, 0, 7, 1, 4'h3));
    chk("R4 stby writable while running", 32'(tmr_stby_run), 32'h0);
    chk("R4 sel frozen while running", 32'(presc_sel), 32'h5);
    chk("R4 cap frozen while running", 32'(cap_en), 32'hA);
  endtask

  task automatic t_disable_same_access();
    wr(8'h00, ctl(0, 0, 3, 1, 4'h1));
    chk("R4 enable cleared", 32'(tmr_en), 32'h0);
    chk("R4 sel kept on clearing write", 32'(presc_sel), 32'h5);
    chk("R4 sync kept on clearing write", 32'(presc_sync), 32'h2);
    wr(8'h00, ctl(0, 0, 3, 1, 4'h1));
    chk("R4 sel loads while disabled", 32'(presc_sel), 32'h3);
  endtask

  task automatic t_ratio();
    for (int s = 0; s < 8; s++) begin
      wr(8'h00, ctl(0, 0, s, 0, 0));
      chk("R9 ratio decode", 32'(presc_ratio), 32'(want_ratio(s)));
    end
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); chk("R10 unmapped reads 0", d, 32'h0);
    wr(8'h05, 32'h0);         rd(8'h05, d); chk("R10 unaligned reads 0", d, 32'h0);
    rd(8'h04, d); chk("R10 neighbour untouched", d, 32'h0000_FFFF);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(8'h00, ctl(1, 1, 6, 1, 4'hF));
    wr(8'h18, 32'hFFFF_FFFF);
    chk("R7 debug writable while running", 32'(dbg_cfg), 32'h1);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h00; wdata = 32'h0000_0001;
    @(negedge clk);
    chk("R5 busy raised", 32'(srst_busy), 32'h1);
    chk("R5 other fields ignored", 32'(tmr_en), 32'h1);
    chk("R5 ctrl bit0 reads 1", rdata & 32'h1, 32'h1);
    addr = 8'h18; wdata = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 busy cleared", 32'(srst_busy), 32'h0);
    chk("R6 disabled", 32'(tmr_en), 32'h0);
    chk("R6 fault A cleared", flt_a_cfg, 32'h0);
    chk("R6 drive cleared", drv_cfg, 32'h0);
    chk("R6 ratio back to 1", 32'(presc_ratio), 32'h1);
    rd(8'h00, d); chk("R6 ctrl cleared", d, 32'h0);
    chk("R8 debug write during busy dropped", 32'(dbg_cfg), 32'h1);
    wr(8'h04, 32'h0000_0077); chk("R3 write after reset", flt_a_cfg, 32'h0000_0077);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_disabled();
    t_enable_same_access();
    t_protect_running();
    t_disable_same_access();
    t_ratio();
    t_unmapped();
    t_soft_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule